// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block holds a small pool of reservation stations that feed one class of functional unit in a dynamically scheduled core. An operation is issued with a destination register and two source registers. Each source is resolved through a per-register producer table. A source with no pending producer takes its value from the local register file. A source with a pending producer keeps that producer's tag and waits for it. The destination register is renamed to the tag of the station that receives the operation.

Every cycle the block watches one shared result bus, which carries a tag and a value. Each station whose operand waits on the broadcast tag copies the value into that operand. A station whose both operands are present is offered to the functional unit. When several stations are ready, the lowest-numbered one goes first. A station stays allocated until its own result appears on the bus. A broadcast updates the register file only for a register whose pending producer is still that tag, so results from producers that have been overtaken are not written back. A read port exposes any register's value and pending tag.

Top module: `rs_pool`

## Requirements
- R1: After reset, no station is occupied. `iss_ready` is 1, `iss_tag` is 1, `disp_valid` is 0, and every register reads value 0 with pending tag 0.
- R2: An accepted issue goes to the lowest-numbered free station. Station k (counting from 0) carries tag k+1, and `iss_tag` shows that tag whenever a station is free.
- R3: While all stations are occupied, `iss_ready` is 0 and `iss_tag` is 0. An issue request in that state has no effect: it neither renames a register nor occupies a station.
- R4: Tag 0 means the operand is present. A source register with pending tag 0 supplies its register-file value. Otherwise the station keeps that register's pending tag and waits for it.
- R5: When the result bus carries a nonzero tag, every occupied station that waits on that tag for either operand takes the bus value in that same cycle.
- R6: If a source's pending tag equals the tag on the bus in the cycle of issue, the operand is taken from the bus and is present at once.
- R7: A station is offered for dispatch only when both operands are present. The offer is visible in the cycle after the issue or the capture that completed it.
- R8: Among the stations that are ready and not yet dispatched, the lowest-numbered one is offered, with its tag, operation and both operand values. Each issued operation is offered exactly once.
- R9: A station becomes free in the cycle after its own tag is broadcast, and it can be issued to from then on.
- R10: An accepted issue sets the destination register's pending tag to the issuing station's tag from the next cycle on. This holds even when a broadcast clears that register in the same cycle.
- R11: A broadcast writes a register, and clears its pending tag to 0, only when the register's pending tag equals the broadcast tag. Registers with any other pending tag keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued instruction |
| iss_dst | input | REG_W | Destination register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_ready | output | 1 | A station is free; an issue request is accepted |
| iss_tag | output | TAG_W | Tag that the next accepted issue receives (0 when full) |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Producer tag on the result bus |
| cdb_value | input | DATA_W | Result value on the result bus |
| disp_valid | output | 1 | An operation is offered to the functional unit |
| disp_tag | output | TAG_W | Tag of the offered operation |
| disp_op | output | OP_W | Operation code of the offered operation |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| rd_addr | input | REG_W | Register read address |
| rd_tag | output | TAG_W | Pending producer tag of the addressed register |
| rd_value | output | DATA_W | Register-file value of the addressed register |

## Verification
Two things can happen in the same cycle. An issue can occur while a broadcast carries the very tag that the issue reads for a source, or the tag that the issue's destination register is waiting on. The stimulus table provokes both cases. It issues a reader of a register in the cycle its producer broadcasts, and it renames a register in the cycle its previous producer writes it. The first case is judged by the operand values that reach dispatch. The second is judged through the read port: the register must hold the broadcast value and still show the new tag. A stale broadcast, aimed at a register that has since been renamed, is judged the same way: the register's value must stay unchanged.

// File: rtl/rs_pkg.sv
package rs_pkg;
    // Default sizing shared by the pool, its helpers and its checker.
    localparam int RS_COUNT_DEF  = 4;
    localparam int RS_TAG_W_DEF  = 3;
    localparam int RS_DATA_W_DEF = 16;
    localparam int RS_OP_W_DEF   = 4;
    localparam int RS_REGS_DEF   = 8;

    // Tag value meaning "no pending producer".
    localparam int RS_TAG_NONE = 0;
endpackage

// File: rtl/rs_pick.sv
// Lowest-index picker over a request vector.
module rs_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_regstat.sv
// Register file plus per-register pending-producer table.
module rs_regstat #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 3,
    parameter int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_val,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_val,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              ren_en,
    input  logic [REG_W-1:0]  ren_reg,
    input  logic [TAG_W-1:0]  ren_tag
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] val;
        logic [NUM_REGS-1:0][TAG_W-1:0]  tag;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            // Only the newest producer of a register may write it.
            if (cdb_valid && (cdb_tag != TAG_W'(rs_pkg::RS_TAG_NONE)) &&
                (rf_q.tag[r] == cdb_tag)) begin
                rf_d.val[r] = cdb_value;
                rf_d.tag[r] = TAG_W'(rs_pkg::RS_TAG_NONE);
            end
        end
        // A rename in the same cycle overrides the clear.
        if (ren_en) begin
            rf_d.tag[ren_reg] = ren_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign a_tag  = rf_q.tag[src_a];
    assign a_val  = rf_q.val[src_a];
    assign b_tag  = rf_q.tag[src_b];
    assign b_val  = rf_q.val[src_b];
    assign rd_tag = rf_q.tag[rd_addr];
    assign rd_val = rf_q.val[rd_addr];
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
    parameter int NUM_RS   = rs_pkg::RS_COUNT_DEF,
    parameter int TAG_W    = rs_pkg::RS_TAG_W_DEF,
    parameter int DATA_W   = rs_pkg::RS_DATA_W_DEF,
    parameter int OP_W     = rs_pkg::RS_OP_W_DEF,
    parameter int NUM_REGS = rs_pkg::RS_REGS_DEF,
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src_a,
    input  logic [REG_W-1:0]  iss_src_b,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_value
);
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;
    localparam logic [TAG_W-1:0] NO_TAG = TAG_W'(rs_pkg::RS_TAG_NONE);

    typedef struct packed {
        logic              busy;
        logic              sent;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  ta;
        logic [TAG_W-1:0]  tb;
        logic [DATA_W-1:0] va;
        logic [DATA_W-1:0] vb;
    } stn_t;

    typedef struct packed {
        stn_t [NUM_RS-1:0] stn;
    } pool_t;

    pool_t st_d, st_q;

    logic [NUM_RS-1:0] free_req;
    logic [NUM_RS-1:0] rdy_req;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  disp_idx;
    logic              iss_fire;

    logic [TAG_W-1:0]  src_a_tag, src_b_tag;
    logic [DATA_W-1:0] src_a_val, src_b_val;
    logic              a_hit, b_hit;
    logic [TAG_W-1:0]  a_tag_eff, b_tag_eff;
    logic [DATA_W-1:0] a_val_eff, b_val_eff;

    // Request vectors for the two pickers.
    generate
        for (genvar g = 0; g < NUM_RS; g++) begin : g_req
            assign free_req[g] = !st_q.stn[g].busy;
            assign rdy_req[g]  = st_q.stn[g].busy && !st_q.stn[g].sent &&
                                 (st_q.stn[g].ta == NO_TAG) &&
                                 (st_q.stn[g].tb == NO_TAG);
        end
    endgenerate

    rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_free_pick (
        .req   (free_req),
        .found (iss_ready),
        .idx   (free_idx)
    );

    rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_disp_pick (
        .req   (rdy_req),
        .found (disp_valid),
        .idx   (disp_idx)
    );

    assign iss_tag  = iss_ready ? TAG_W'(free_idx) + TAG_W'(1) : NO_TAG;
    assign iss_fire = iss_valid && iss_ready;

    rs_regstat #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W),
        .REG_W    (REG_W)
    ) u_regstat (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (iss_src_a),
        .src_b     (iss_src_b),
        .rd_addr   (rd_addr),
        .a_tag     (src_a_tag),
        .a_val     (src_a_val),
        .b_tag     (src_b_tag),
        .b_val     (src_b_val),
        .rd_tag    (rd_tag),
        .rd_val    (rd_value),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .ren_en    (iss_fire),
        .ren_reg   (iss_dst),
        .ren_tag   (iss_tag)
    );

    // Source resolution at issue, with same-cycle bus bypass.
    always_comb begin
        a_hit     = cdb_valid && (src_a_tag != NO_TAG) && (cdb_tag == src_a_tag);
        b_hit     = cdb_valid && (src_b_tag != NO_TAG) && (cdb_tag == src_b_tag);
        a_tag_eff = a_hit ? NO_TAG : src_a_tag;
        b_tag_eff = b_hit ? NO_TAG : src_b_tag;
        a_val_eff = a_hit ? cdb_value : src_a_val;
        b_val_eff = b_hit ? cdb_value : src_b_val;
    end

    // Dispatch outputs come straight from registered station state.
    always_comb begin
        disp_tag = NO_TAG;
        disp_op  = '0;
        disp_a   = '0;
        disp_b   = '0;
        if (disp_valid) begin
            disp_tag = TAG_W'(disp_idx) + TAG_W'(1);
            disp_op  = st_q.stn[disp_idx].op;
            disp_a   = st_q.stn[disp_idx].va;
            disp_b   = st_q.stn[disp_idx].vb;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_RS; i++) begin
            if (st_q.stn[i].busy) begin
                if (cdb_valid && (cdb_tag != NO_TAG)) begin
                    if (st_q.stn[i].ta == cdb_tag) begin
                        st_d.stn[i].va = cdb_value;
                        st_d.stn[i].ta = NO_TAG;
                    end
                    if (st_q.stn[i].tb == cdb_tag) begin
                        st_d.stn[i].vb = cdb_value;
                        st_d.stn[i].tb = NO_TAG;
                    end
                end
                if (disp_valid && (disp_idx == IDX_W'(i))) begin
                    st_d.stn[i].sent = 1'b1;
                end
                if (cdb_valid && (cdb_tag == TAG_W'(i + 1))) begin
                    st_d.stn[i].busy = 1'b0;
                    st_d.stn[i].sent = 1'b0;
                end
            end
            if (iss_fire && (free_idx == IDX_W'(i))) begin
                st_d.stn[i].busy = 1'b1;
                st_d.stn[i].sent = 1'b0;
                st_d.stn[i].op   = iss_op;
                st_d.stn[i].ta   = a_tag_eff;
                st_d.stn[i].tb   = b_tag_eff;
                st_d.stn[i].va   = a_val_eff;
                st_d.stn[i].vb   = b_val_eff;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    parameter int REG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [TAG_W-1:0]  iss_tag,
    input logic [REG_W-1:0]  iss_dst,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic [DATA_W-1:0] cdb_value,
    input logic              disp_valid,
    input logic [TAG_W-1:0]  disp_tag,
    input logic [REG_W-1:0]  rd_addr,
    input logic [TAG_W-1:0]  rd_tag,
    input logic [DATA_W-1:0] rd_value
);
    logic ren_here;
    assign ren_here = iss_valid && iss_ready && (iss_dst == rd_addr);

    AST_DISP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && (disp_tag == $past(disp_tag)))); // R8

    AST_RENAME_DST: assert property (@(posedge clk) disable iff (!rst_n)
        ren_here |=> (rd_addr != $past(rd_addr)) || (rd_tag == $past(iss_tag))); // R10

    AST_WRITE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && (cdb_tag != '0) && (rd_tag == cdb_tag) && !ren_here)
        |=> (rd_addr != $past(rd_addr)) ||
            ((rd_tag == '0) && (rd_value == $past(cdb_value)))); // R11

    AST_STALE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && (rd_tag != cdb_tag) && !ren_here)
        |=> (rd_addr != $past(rd_addr)) || $stable(rd_value)); // R11

    AST_FULL_NO_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !(cdb_valid && (rd_tag == cdb_tag)))
        |=> (rd_addr != $past(rd_addr)) || $stable(rd_tag)); // R3
endmodule

bind rs_pool rs_pool_chk #(
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_tag    (iss_tag),
    .iss_dst    (iss_dst),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag),
    .cdb_value  (cdb_value),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag),
    .rd_addr    (rd_addr),
    .rd_tag     (rd_tag),
    .rd_value   (rd_value)
);

// File: tb/rs_pool_bench.sv
`timescale 1ns/1ps
module rs_pool_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic [2:0]  iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        cdb_valid = 1'b0;
    logic [2:0]  cdb_tag = '0;
    logic [15:0] cdb_value = '0;
    logic        disp_valid;
    logic [2:0]  disp_tag;
    logic [3:0]  disp_op;
    logic [15:0] disp_a, disp_b;
    logic [2:0]  rd_addr = 3'd2;
    logic [2:0]  rd_tag;
    logic [15:0] rd_value;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rs_pool u_rs_pool (.*);

    typedef struct packed {
        logic        iv;  logic [3:0] op;  logic [2:0] dst; logic [2:0] sa; logic [2:0] sb;
        logic        cv;  logic [2:0] ct;  logic [15:0] cval;
        logic        rdy; logic [2:0] itag;
        logic        dv;  logic [2:0] dtag; logic [3:0] dop; logic [15:0] da; logic [15:0] db;
    } vec_t;

    // Expected columns are the outputs seen before the clock edge of that row.
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1,1,1,0,0, 0,0,16'h0,    1,1, 0,0,0,16'h0,16'h0},       // R2 first issue, R4 ready srcs
        '{1,2,2,1,0, 0,0,16'h0,    1,2, 1,1,1,16'h0,16'h0},       // R7 dispatch next cycle
        '{1,3,3,1,2, 1,1,16'h0011, 1,3, 0,0,0,16'h0,16'h0},       // R6 bypass on issue, R5
        '{0,0,0,0,0, 0,0,16'h0,    1,1, 1,2,2,16'h0011,16'h0},    // R5 captured value
        '{1,4,1,3,2, 0,0,16'h0,    1,1, 0,0,0,16'h0,16'h0},       // R4 both waiting
        '{1,5,4,2,1, 1,2,16'h0022, 1,4, 0,0,0,16'h0,16'h0},       // R5 two stations capture
        '{1,6,5,0,0, 0,0,16'h0,    1,2, 1,3,3,16'h0011,16'h0022}, // R9 reuse freed station
        '{1,7,6,0,0, 0,0,16'h0,    0,0, 1,2,6,16'h0,16'h0},       // R3 full, issue dropped
        '{0,0,0,0,0, 1,3,16'h0033, 0,0, 0,0,0,16'h0,16'h0},
        '{0,0,0,0,0, 1,2,16'h0055, 1,3, 1,1,4,16'h0033,16'h0022}, // R8
        '{0,0,0,0,0, 1,1,16'h0066, 1,2, 0,0,0,16'h0,16'h0},
        '{0,0,0,0,0, 0,0,16'h0,    1,1, 1,4,5,16'h0022,16'h0066},
        '{1,8,2,0,0, 0,0,16'h0,    1,1, 0,0,0,16'h0,16'h0},       // R10 rename r2
        '{1,9,2,2,0, 0,0,16'h0,    1,2, 1,1,8,16'h0,16'h0},       // rename r2 again
        '{0,0,0,0,0, 1,1,16'h0077, 1,3, 0,0,0,16'h0,16'h0},       // R11 stale broadcast
        '{1,10,4,4,0,1,4,16'h0088, 1,1, 1,2,9,16'h0077,16'h0},    // R10 rename beats clear
        '{0,0,0,0,0, 0,0,16'h0,    1,3, 1,1,10,16'h0088,16'h0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic chk_reg(input logic [2:0] r, input logic [15:0] v, input logic [2:0] t, input string req);
        rd_addr = r;
        #1;
        chk(rd_value == v, req, rd_value, v);
        chk(rd_tag == t, req, rd_tag, t);
    endtask

    task automatic idle();
        iss_valid = 0; cdb_valid = 0;
    endtask

    initial begin
        #(20 * 5000);
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        #5;
        chk(iss_ready == 1, "R1", iss_ready, 1);
        chk(iss_tag == 1, "R1", iss_tag, 1);
        chk(disp_valid == 0, "R1", disp_valid, 0);
        chk_reg(3'd4, 16'h0, 3'd0, "R1");
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        rd_addr = 3'd2;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            iss_valid = VEC[k].iv; iss_op = VEC[k].op; iss_dst = VEC[k].dst;
            iss_src_a = VEC[k].sa; iss_src_b = VEC[k].sb;
            cdb_valid = VEC[k].cv; cdb_tag = VEC[k].ct; cdb_value = VEC[k].cval;
            #1;
            chk(iss_ready == VEC[k].rdy, "R3", iss_ready, VEC[k].rdy);
            chk(iss_tag == VEC[k].itag, "R2", iss_tag, VEC[k].itag);
            chk(disp_valid == VEC[k].dv, "R7", disp_valid, VEC[k].dv);
            if (VEC[k].dv) begin
                chk(disp_tag == VEC[k].dtag, "R8", disp_tag, VEC[k].dtag);
                chk(disp_op == VEC[k].dop, "R8", disp_op, VEC[k].dop);
                chk(disp_a == VEC[k].da, "R5", disp_a, VEC[k].da);
                chk(disp_b == VEC[k].db, "R6", disp_b, VEC[k].db);
            end
        end
        @(negedge clk);
        idle();
        #1;
        chk_reg(3'd2, 16'h0022, 3'd2, "R11");   // stale tag 1 did not write r2
        chk_reg(3'd4, 16'h0088, 3'd1, "R10");   // written, yet renamed to tag 1
        chk_reg(3'd6, 16'h0000, 3'd0, "R3");    // dropped issue did not rename r6
        chk_reg(3'd1, 16'h0066, 3'd0, "R11");
        chk_reg(3'd3, 16'h0033, 3'd0, "R11");
        chk_reg(3'd5, 16'h0055, 3'd0, "R11");

        // R9: station 1 (tag 2) frees after its broadcast
        @(negedge clk);
        cdb_valid = 1; cdb_tag = 3'd2; cdb_value = 16'h0099;
        #1;
        chk(iss_tag == 3'd3, "R9", iss_tag, 3);
        @(negedge clk);
        idle();
        #1;
        chk(iss_tag == 3'd2, "R9", iss_tag, 2);
        chk_reg(3'd2, 16'h0099, 3'd0, "R11");

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 0;
        #1;
        chk(iss_tag == 3'd1, "R1", iss_tag, 1);
        chk(disp_valid == 0, "R1", disp_valid, 0);
        chk_reg(3'd4, 16'h0, 3'd0, "R1");
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule